// File: doc/BRIEF.md
# Integer multiply/divide unit

This block performs integer multiplication and division on two 32-bit register operands for a processor's execute stage. A 3-bit function code picks one of eight results: the low product word, the high product word under three signedness combinations, the signed or unsigned quotient, or the signed or unsigned remainder. In the surrounding instruction encoding, all eight share the register-register major opcode `0110011` with a secondary function field of `0x01`. Only the function code enters this block.

A request is presented with a one-cycle `start_i` pulse. The unit stays busy until it raises `done_o` for one cycle with the result. Multiplication uses a single-cycle product. Division uses a restoring divider that retires one quotient bit per clock, followed by a sign fix-up cycle.

The controller has five states. ST_IDLE waits for a request. ST_MULT registers the product. ST_DIVIDE runs the WIDTH divider steps. ST_FIXUP applies signs and the special cases. ST_FINISH presents the result. The transitions are:
- ST_IDLE goes to ST_MULT on a start with a multiply code, and to ST_DIVIDE on a start with a divide or remainder code.
- ST_MULT goes to ST_FINISH after one cycle.
- ST_DIVIDE goes to ST_FIXUP after its last step.
- ST_FIXUP goes to ST_FINISH.
- ST_FINISH always returns to ST_IDLE.

Top module: `imd_unit`

## Requirements
- R1: Function code 0 returns the low 32 bits of the product of opa_i and opb_i.
- R2: Function codes 1, 2 and 3 return the upper 32 bits of the 64-bit product. Code 1 treats the operands as signed by signed, code 2 as signed opa_i by unsigned opb_i, and code 3 as unsigned by unsigned.
- R3: Function code 4 returns the signed quotient and code 5 the unsigned quotient. The signed quotient is truncated toward zero.
- R4: Function code 6 returns the signed remainder and code 7 the unsigned remainder. A nonzero signed remainder has the sign of the dividend.
- R5: When the divisor is zero, codes 4 and 5 return all ones and codes 6 and 7 return the dividend.
- R6: For 0x80000000 divided by 0xFFFFFFFF as signed values, code 4 returns 0x80000000 and code 6 returns 0.
- R7: After reset, busy_o and done_o are 0. busy_o rises on the edge that accepts a start and stays high through the cycle in which done_o is high.
- R8: done_o is high for exactly one cycle per accepted request, with the result on result_o in that cycle. It is followed by a cycle with busy_o low.
- R9: Counting the accepting edge as edge 0, done_o appears after edge 1 for multiply codes and after edge WIDTH+1 for divide and remainder codes.
- R10: A start_i pulse while busy_o is high is ignored. The running request completes with its own operands and code, and no extra done_o follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted only when idle |
| fn_i | input | 3 | Function code selecting the operation |
| opa_i | input | WIDTH | First operand (multiplicand or dividend) |
| opb_i | input | WIDTH | Second operand (multiplier or divisor) |
| busy_o | output | 1 | High from acceptance through the done cycle |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | WIDTH | Result, valid while done_o is high |

## Verification
The bench builds the unit with its default WIDTH of 32, so every operand pattern maps directly onto 64-bit integer arithmetic in the reference model. At this width the most negative dividend 0x80000000 and the all-ones divisor can be driven directly, which covers the signed-overflow and high-half signedness corners. The 34-cycle divide latency is also short enough to fire a second request in the middle of a running division and observe that it is dropped.

// File: rtl/imd_pkg.sv
package imd_pkg;

    // Function codes; the numeric values are fixed by the instruction encoding
    typedef enum logic [2:0] {
        FN_MUL_LO    = 3'd0,
        FN_MUL_HI_SS = 3'd1,
        FN_MUL_HI_SU = 3'd2,
        FN_MUL_HI_UU = 3'd3,
        FN_QUO_S     = 3'd4,
        FN_QUO_U     = 3'd5,
        FN_REM_S     = 3'd6,
        FN_REM_U     = 3'd7
    } imd_fn_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_MULT   = 3'd1,
        ST_DIVIDE = 3'd2,
        ST_FIXUP  = 3'd3,
        ST_FINISH = 3'd4
    } imd_state_e;

endpackage

// File: rtl/imd_mul.sv
module imd_mul #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       sel_i,
    output logic [WIDTH-1:0] prod_o
);
    localparam int PW = 2 * WIDTH;

    logic              a_signed;
    logic              b_signed;
    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] prod;

    always_comb begin
        // sel 1: signed x signed, sel 2: signed x unsigned, sel 3: unsigned x unsigned
        a_signed = (sel_i == 2'd1) || (sel_i == 2'd2);
        b_signed = (sel_i == 2'd1);
        a_ext    = {{WIDTH{a_signed & a_i[WIDTH-1]}}, a_i};
        b_ext    = {{WIDTH{b_signed & b_i[WIDTH-1]}}, b_i};
        prod     = a_ext * b_ext;
        prod_o   = (sel_i == 2'd0) ? prod[WIDTH-1:0] : prod[PW-1:WIDTH];
    end

endmodule

// File: rtl/imd_div.sv
module imd_div #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] dvd_i,
    input  logic [WIDTH-1:0] dvs_i,
    output logic [WIDTH-1:0] quo_o,
    output logic [WIDTH-1:0] rem_o
);
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] dvs_q;
    logic [WIDTH:0]   shifted;
    logic             fits;

    always_comb begin
        shifted = {acc_q, quo_q[WIDTH-1]};
        fits    = shifted >= {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            acc_q <= '0;
            quo_q <= dvd_i;
            dvs_q <= dvs_i;
        end else if (step_i) begin
            if (fits) begin
                acc_q <= WIDTH'(shifted - {1'b0, dvs_q});
            end else begin
                acc_q <= shifted[WIDTH-1:0];
            end
            quo_q <= {quo_q[WIDTH-2:0], fits};
        end
    end

    assign quo_o = quo_q;
    assign rem_o = acc_q;

    // restoring invariant: partial remainder never reaches the divisor
    AST_PARTIAL_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && dvs_q != '0) |-> (acc_q < dvs_q)); // R3

endmodule

// File: rtl/imd_unit.sv
module imd_unit
    import imd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       fn_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    localparam int CW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    imd_state_e       state_q, state_nx;
    imd_fn_e          fn_q;
    logic [WIDTH-1:0] a_q, b_q, res_q;
    logic [CW-1:0]    cnt_q;

    logic             accept;
    logic             in_neg_a, in_neg_b;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic [WIDTH-1:0] prod;
    logic [WIDTH-1:0] quo_mag, rem_mag;
    logic [WIDTH-1:0] fix_val;
    logic             sgn, q_neg, r_neg;

    assign accept = start_i && (state_q == ST_IDLE);

    // operand magnitudes for the divider; signed divide codes have fn bit 0 clear
    always_comb begin
        in_neg_a = !fn_i[0] && opa_i[WIDTH-1];
        in_neg_b = !fn_i[0] && opb_i[WIDTH-1];
        mag_a    = in_neg_a ? (~opa_i + 1'b1) : opa_i;
        mag_b    = in_neg_b ? (~opb_i + 1'b1) : opb_i;
    end

    imd_mul #(.WIDTH(WIDTH)) u_mul (
        .a_i    (a_q),
        .b_i    (b_q),
        .sel_i  (fn_q[1:0]),
        .prod_o (prod)
    );

    imd_div #(.WIDTH(WIDTH)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept && fn_i[2]),
        .step_i (state_q == ST_DIVIDE),
        .dvd_i  (mag_a),
        .dvs_i  (mag_b),
        .quo_o  (quo_mag),
        .rem_o  (rem_mag)
    );

    // sign fix-up and special cases
    always_comb begin
        sgn   = !fn_q[0];
        q_neg = sgn && (a_q[WIDTH-1] ^ b_q[WIDTH-1]);
        r_neg = sgn && a_q[WIDTH-1];
        if (b_q == '0) begin
            fix_val = fn_q[1] ? a_q : '1;
        end else if (fn_q[1]) begin
            fix_val = r_neg ? (~rem_mag + 1'b1) : rem_mag;
        end else begin
            fix_val = q_neg ? (~quo_mag + 1'b1) : quo_mag;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_nx = fn_i[2] ? ST_DIVIDE : ST_MULT;
            end
            ST_MULT:   state_nx = ST_FINISH;
            ST_DIVIDE: begin
                if (cnt_q == LAST_STEP) state_nx = ST_FIXUP;
            end
            ST_FIXUP:  state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fn_q  <= FN_MUL_LO;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
            cnt_q <= '0;
        end else begin
            if (accept) begin
                fn_q  <= imd_fn_e'(fn_i);
                a_q   <= opa_i;
                b_q   <= opb_i;
                cnt_q <= '0;
            end else if (state_q == ST_DIVIDE) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_MULT)  res_q <= prod;
            if (state_q == ST_FIXUP) res_q <= fix_val;
        end
    end

    // outputs
    always_comb begin
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_FINISH);
        result_o = res_q;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R7
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> ($stable(a_q) && $stable(b_q) && $stable(fn_q))); // R10
    AST_DIV_ZERO_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fn_q[2] && !fn_q[1] && b_q == '0) |-> (result_o == '1)); // R5
    AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fn_q == FN_REM_S && b_q != '0 && result_o != '0)
            |-> (result_o[WIDTH-1] == a_q[WIDTH-1])); // R4

endmodule

// File: tb/imd_unit_test.sv
`timescale 1ns/1ps
module imd_unit_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [2:0]   fn_i = 3'd0;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] result_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    imd_unit #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fn_i(fn_i),
        .opa_i(opa_i), .opb_i(opb_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [2:0] fn, input logic [W-1:0] a, input logic [W-1:0] b);
        longint x, y, p;
        int sa, sb;
        int unsigned ua, ub;
        sa = int'(a); sb = int'(b); ua = a; ub = b;
        case (fn)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                x = (fn == 3'd1 || fn == 3'd2) ? longint'(sa) : longint'(ua);
                y = (fn == 3'd1) ? longint'(sb) : longint'(ub);
                p = x * y;
                return (fn == 3'd0) ? p[31:0] : p[63:32];
            end
            3'd4: begin
                if (sb == 0) return '1;
                if (sa == 32'sh80000000 && sb == -1) return a;
                return sa / sb;
            end
            3'd5: return (ub == 0) ? '1 : (ua / ub);
            3'd6: begin
                if (sb == 0) return a;
                if (sa == 32'sh80000000 && sb == -1) return '0;
                return sa % sb;
            end
            default: return (ub == 0) ? a : (ua % ub);
        endcase
    endfunction

    // issue one request, wait for done; checks busy coverage and single done pulse
    task automatic run_op(input logic [2:0] fn, input logic [W-1:0] a, input logic [W-1:0] b,
                          output logic [W-1:0] res, output int lat);
        bit busy_gap = 1'b0;
        @(negedge clk);
        start_i = 1'b1; fn_i = fn; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 200) begin
            if (!busy_o) busy_gap = 1'b1;
            @(negedge clk);
            lat++;
        end
        res = result_o;
        chk(!busy_gap && busy_o && done_o, "R7 busy held until done", W'(busy_o), 1);
        @(negedge clk);
        chk(!done_o && !busy_o, "R8 done one cycle then idle", W'({busy_o, done_o}), 0);
    endtask

    task automatic op_check(input logic [2:0] fn, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        logic [W-1:0] r;
        int lat;
        run_op(fn, a, b, r, lat);
        chk(r == model(fn, a, b), req, r, model(fn, a, b));
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o, "R7 reset state", W'({busy_o, done_o}), 0);
    endtask

    task automatic t_mul_low();
        logic [W-1:0] r;
        int lat;
        run_op(3'd0, 32'd7, 32'd6, r, lat);
        chk(r == 32'd42, "R1 7*6", r, 32'd42);
        chk(lat == 2, "R9 multiply latency", W'(lat), 2);
        op_check(3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R1 low of -1*-1");
        op_check(3'd0, 32'h12345678, 32'h9ABCDEF0, "R1 mixed pattern");
    endtask

    task automatic t_mul_high();
        logic [W-1:0] r;
        int lat;
        run_op(3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, r, lat);
        chk(r == 32'h0, "R2 signed*signed high", r, 32'h0);
        run_op(3'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, r, lat);
        chk(r == 32'hFFFFFFFF, "R2 signed*unsigned high", r, 32'hFFFFFFFF);
        run_op(3'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, r, lat);
        chk(r == 32'hFFFFFFFE, "R2 unsigned*unsigned high", r, 32'hFFFFFFFE);
        op_check(3'd1, 32'h80000000, 32'h80000000, "R2 min*min signed");
        op_check(3'd2, 32'h80000000, 32'h7FFFFFFF, "R2 su min");
        op_check(3'd3, 32'hDEADBEEF, 32'h01234567, "R2 uu pattern");
    endtask

    task automatic t_quotient();
        logic [W-1:0] r;
        int lat;
        run_op(3'd4, 32'hFFFFFFF9, 32'd2, r, lat);
        chk(r == 32'hFFFFFFFD, "R3 -7/2 toward zero", r, 32'hFFFFFFFD);
        chk(lat == W + 2, "R9 divide latency", W'(lat), W + 2);
        op_check(3'd5, 32'hFFFFFFF9, 32'd2, "R3 unsigned quotient");
        op_check(3'd4, 32'd100, 32'hFFFFFFF9, "R3 100/-7");
        op_check(3'd5, 32'd5, 32'd9, "R3 small over large");
    endtask

    task automatic t_remainder();
        logic [W-1:0] r;
        int lat;
        run_op(3'd6, 32'hFFFFFFF9, 32'd2, r, lat);
        chk(r == 32'hFFFFFFFF, "R4 -7 rem 2", r, 32'hFFFFFFFF);
        run_op(3'd6, 32'd7, 32'hFFFFFFFE, r, lat);
        chk(r == 32'd1, "R4 7 rem -2", r, 32'd1);
        op_check(3'd7, 32'hFFFFFFF9, 32'd10, "R4 unsigned remainder");
    endtask

    task automatic t_divzero();
        logic [W-1:0] r;
        int lat;
        run_op(3'd4, 32'hFFFFFF00, 32'd0, r, lat);
        chk(r == 32'hFFFFFFFF, "R5 signed quotient by zero", r, 32'hFFFFFFFF);
        run_op(3'd5, 32'd1234, 32'd0, r, lat);
        chk(r == 32'hFFFFFFFF, "R5 unsigned quotient by zero", r, 32'hFFFFFFFF);
        run_op(3'd6, 32'hFFFFFF00, 32'd0, r, lat);
        chk(r == 32'hFFFFFF00, "R5 signed remainder by zero", r, 32'hFFFFFF00);
        run_op(3'd7, 32'd1234, 32'd0, r, lat);
        chk(r == 32'd1234, "R5 unsigned remainder by zero", r, 32'd1234);
    endtask

    task automatic t_overflow();
        logic [W-1:0] r;
        int lat;
        run_op(3'd4, 32'h80000000, 32'hFFFFFFFF, r, lat);
        chk(r == 32'h80000000, "R6 overflow quotient", r, 32'h80000000);
        run_op(3'd6, 32'h80000000, 32'hFFFFFFFF, r, lat);
        chk(r == 32'h0, "R6 overflow remainder", r, 32'h0);
    endtask

    task automatic t_ignore();
        int lat = 1;
        int extra = 0;
        @(negedge clk);
        start_i = 1'b1; fn_i = 3'd4; opa_i = 32'd100; opb_i = 32'd7;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && lat < 200) begin
            if (lat == 5) begin
                start_i = 1'b1; fn_i = 3'd0; opa_i = 32'd3; opb_i = 32'd5;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        chk(result_o == 32'd14, "R10 running request kept", result_o, 32'd14);
        chk(lat == W + 2, "R10 latency unchanged", W'(lat), W + 2);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        chk(extra == 0, "R10 no extra done", W'(extra), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mul_low();
        t_mul_high();
        t_quotient();
        t_remainder();
        t_divzero();
        t_overflow();
        t_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule